// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM from reset to a programmed, ready state. It drives the chip-select, row-strobe, column-strobe, write-enable, address, bank-select and clock-enable pins through a fixed power-up order. First it holds the bus quiet for a long settling wait. It then closes every bank and runs two refresh cycles. Last, it writes a mode word that is supplied as a parameter. Each step is followed by a counted gap. When the gap after the mode write has elapsed, the block raises a ready flag, and from then on it leaves the bus on NOP so that the normal controller can take over.

The settling wait is given as a clock frequency in MHz times a wait in microseconds. The gaps after precharge, after each refresh and after the mode write are separate cycle-count parameters, and each must be at least 2. All outputs are registered. There is no data path, so none of the pins has a handshake; every port is a plain control or status signal.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted (rst_n low), the command pins read chip-select high (inhibit), cke is 1 and ready is 0.
- R2: After reset is released, exactly CLK_MHZ*WAIT_US cycles of NOP ({cs_n,ras_n,cas_n,we_n}=0111) are issued. The next command is a precharge (0010) with addr[10]=1, which closes all banks.
- R3: The first auto refresh (0001) is issued exactly T_RP cycles after the precharge.
- R4: The second auto refresh is issued exactly T_RC cycles after the first. The mode load (0000) is issued exactly T_RC cycles after the second refresh.
- R5: During the mode load, addr equals MODE_WORD with bits 12..10 forced to 0, and ba is 0.
- R6: ready stays 0 until exactly T_MRD cycles after the mode load. It rises then and remains 1.
- R7: Every cycle between commands, and every cycle after ready, carries NOP.
- R8: cke is 1 in every cycle, both during reset and after it.
- R9: Asserting reset at any point mid-sequence returns the pins to inhibit and restarts the whole sequence from the full wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sequencer and the SDRAM |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins: bit 10 selects all banks on precharge, and the pins carry the mode word on a mode load |
| ba | output | BA_W | Bank select, held at 0 |
| cke | output | 1 | Clock enable, held high |
| ready | output | 1 | Set once initialization is complete |

## Verification
Some rules are checked by the assertions on every cycle:
- the step order into the first refresh and into the mode load;
- the countdown of the gap timer;
- addr[10] being high on every precharge;
- the reserved mode bits being low on every mode load;
- ready staying high and the bus staying on NOP once ready is set.

Other rules need whole scenarios in the bench:
- the exact length of the wait and of each gap;
- the mode word as it appears on the pins;
- ready rising at exactly the right cycle;
- the restart from the full wait after a reset part way through the sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_PRE,
    ST_RP,
    ST_REF1,
    ST_RC1,
    ST_REF2,
    ST_RC2,
    ST_LMR,
    ST_MRD,
    ST_DONE
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sdram_cmd_e;

  function automatic sdram_cmd_e cmd_for_state(init_state_e st);
    case (st)
      ST_PRE:           return CMD_PRE;
      ST_REF1, ST_REF2: return CMD_REF;
      ST_LMR:           return CMD_LMR;
      default:          return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 8,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CNT_W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // The gap counter falls by exactly one per cycle while it runs.
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_RP  = 3,
  parameter int T_RC  = 7,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output init_state_e      state
);

  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 2);

  init_state_e nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    case (state)
      ST_WAIT: if (expired) nxt = ST_PRE;
      ST_PRE:  begin nxt = ST_RP;  load = 1'b1; load_val = RP_LOAD;  end
      ST_RP:   if (expired) nxt = ST_REF1;
      ST_REF1: begin nxt = ST_RC1; load = 1'b1; load_val = RC_LOAD;  end
      ST_RC1:  if (expired) nxt = ST_REF2;
      ST_REF2: begin nxt = ST_RC2; load = 1'b1; load_val = RC_LOAD;  end
      ST_RC2:  if (expired) nxt = ST_LMR;
      ST_LMR:  begin nxt = ST_MRD; load = 1'b1; load_val = MRD_LOAD; end
      ST_MRD:  if (expired) nxt = ST_DONE;
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= nxt;
  end

  assert_ref1_after_rp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REF1) |-> ($past(state) == ST_RP));

  assert_lmr_after_rc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LMR) |-> ($past(state) == ST_RC2));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_DONE));

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  init_state_e       state,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke,
  output logic              ready
);

  localparam int ALL_BANK_BIT = 10;
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANK_BIT;
  localparam logic [ADDR_W-1:0] RSV_MASK  = {ADDR_W{1'b1}} << ALL_BANK_BIT;
  localparam logic [ADDR_W-1:0] MODE_OUT  = MODE_WORD & ~RSV_MASK;

  sdram_cmd_e        cmd_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    cmd_nxt  = cmd_for_state(state);
    addr_nxt = '0;
    if (state == ST_PRE)      addr_nxt = ALL_BANKS;
    else if (state == ST_LMR) addr_nxt = MODE_OUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_INH;
      addr  <= '0;
      ba    <= '0;
      cke   <= 1'b1;
      ready <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_nxt;
      addr  <= addr_nxt;
      ba    <= '0;
      cke   <= 1'b1;
      ready <= (state == ST_DONE);
    end
  end

  assert_pre_all_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == CMD_PRE) |-> addr[ALL_BANK_BIT]);

  assert_lmr_reserved_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == CMD_LMR) |-> ((addr & RSV_MASK) == '0 && ba == '0));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 100,
  parameter int T_RP    = 3,
  parameter int T_RC    = 7,
  parameter int T_MRD   = 2,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0033
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke,
  output logic              ready
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int GAP_MAX  = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                          : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int LEN_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int CNT_W    = $clog2(LEN_MAX + 1);

  logic             expired;
  logic             load;
  logic [CNT_W-1:0] load_val;
  init_state_e      state;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  sdram_init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(expired), .load(load),
    .load_val(load_val), .state(state)
  );

  sdram_init_pins #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .cke(cke), .ready(ready)
  );

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_ready_bus_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_MHZ  = 100;
  localparam int WAIT_US  = 100;
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int T_RP     = 3;
  localparam int T_RC     = 7;
  localparam int T_MRD    = 2;
  localparam logic [12:0] MODE     = 13'h1C33;
  localparam logic [12:0] EXP_MODE = 13'h0033;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, ready;
  logic [12:0] addr;
  logic [1:0]  ba;

  int checks = 0;
  int failures = 0;
  bit cke_bad = 0;
  bit ready_early = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .ADDR_W(13), .BA_W(2), .MODE_WORD(MODE)
  ) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .cke(cke), .ready(ready)
  );

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cke !== 1'b1) cke_bad = 1;
  endtask

  // Counts NOP cycles until the next non-NOP command on the pins.
  task automatic next_cmd(output int nops, output logic [3:0] c);
    nops = 0;
    c = C_NOP;
    for (int i = 0; i < 30000; i++) begin
      tick();
      if (ready) ready_early = 1;
      c = cmd_now();
      if (c != C_NOP) break;
      nops++;
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) tick();
    chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    chk(cke == 1'b1, "R1", "cke in reset", int'(cke), 1);
    chk(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
    ready_early = 0;
  endtask

  task automatic t_wait_phase();
    int n;
    logic [3:0] c;
    rst_n = 1'b1;
    next_cmd(n, c);
    chk(n == WAIT_CYC, "R2", "NOP cycles in wait", n, WAIT_CYC);
    chk(c == C_PRE, "R2", "first command", int'(c), int'(C_PRE));
    chk(addr[10] == 1'b1, "R2", "precharge addr[10]", int'(addr[10]), 1);
  endtask

  task automatic t_refresh_phase();
    int n;
    logic [3:0] c;
    next_cmd(n, c);
    chk(n + 1 == T_RP, "R3", "precharge to refresh gap", n + 1, T_RP);
    chk(c == C_REF, "R3", "first refresh cmd", int'(c), int'(C_REF));
    next_cmd(n, c);
    chk(n + 1 == T_RC, "R4", "refresh to refresh gap", n + 1, T_RC);
    chk(c == C_REF, "R4", "second refresh cmd", int'(c), int'(C_REF));
  endtask

  task automatic t_lmr_phase();
    int n;
    logic [3:0] c;
    next_cmd(n, c);
    chk(n + 1 == T_RC, "R4", "refresh to mode load gap", n + 1, T_RC);
    chk(c == C_LMR, "R5", "mode load cmd", int'(c), int'(C_LMR));
    chk(addr == EXP_MODE, "R5", "mode word on addr", int'(addr), int'(EXP_MODE));
    chk(ba == 2'b00, "R5", "bank during mode load", int'(ba), 0);
  endtask

  task automatic t_ready_phase();
    int k = 0;
    bit nop_bad = 0;
    bit ready_drop = 0;
    chk(ready_early == 0, "R6", "ready before mode load", int'(ready_early), 0);
    for (int i = 0; i < 100; i++) begin
      tick();
      k++;
      if (cmd_now() != C_NOP) nop_bad = 1;
      if (ready) break;
    end
    chk(k == T_MRD, "R6", "mode load to ready", k, T_MRD);
    for (int i = 0; i < 50; i++) begin
      tick();
      if (!ready) ready_drop = 1;
      if (cmd_now() != C_NOP) nop_bad = 1;
    end
    chk(ready_drop == 0, "R6", "ready dropped", int'(ready_drop), 0);
    chk(nop_bad == 0, "R7", "non-NOP after mode load", int'(nop_bad), 0);
    chk(cke_bad == 0, "R8", "cke low seen", int'(cke_bad), 0);
  endtask

  task automatic t_reset_midway();
    int n;
    logic [3:0] c;
    t_wait_phase();
    next_cmd(n, c);
    chk(c == C_REF, "R9", "reached refresh before reset", int'(c), int'(C_REF));
    rst_n = 1'b0;
    #1;
    chk(cs_n == 1'b1, "R9", "inhibit right after mid reset", int'(cs_n), 1);
    t_reset_state();
    t_wait_phase();
    t_refresh_phase();
    t_lmr_phase();
    t_ready_phase();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    t_wait_phase();
    t_refresh_phase();
    t_lmr_phase();
    t_ready_phase();
    t_reset_state();
    t_reset_midway();
    summary();
    $finish;
  end

endmodule